// File: doc/BRIEF.md
# EEPROM Write-Permission and Status Register

This block sits beside the command decoder of a serial EEPROM with 8K bytes and 13-bit addresses. It holds the device status state. That state has two volatile bits: a write-enable latch and a general-purpose flag. It also keeps shadow copies of the nonvolatile fields: a two-bit range-lock code, a two-bit watchdog-period select and a pin-guard enable. The decoder hands the block one-cycle instruction strobes, the data byte of a status write, the target address of an array write and the level of the active-low write-protect pin.

For each request the block decides, in the same cycle, whether an array write or a status write may proceed. The decision uses three inputs: the write-enable latch, the pin-guard bit together with the pin, and the address range covered by the lock code. A granted request is acted on at the next clock edge. The status byte is always presented for reads. SPI shifting, instruction decoding, the cell array and the programming delay are handled outside this block.

Top module: `ee_wp_status`

## Requirements
- R1: After reset the status byte reads 0x00 and no grant is asserted (default shadow value 0).
- R2: A we_set_i strobe sets the write-enable latch at the next edge. A we_clr_i strobe clears it, and we_clr_i wins when both arrive together.
- R3: A flag_set_i strobe sets the flag and a flag_clr_i strobe clears it. The clear wins when both arrive together. The flag is 0 after reset.
- R4: The lock code selects the protected addresses. 00 protects none, 01 protects 0x1800–0x1FFF, 10 protects 0x1000–0x1FFF and 11 protects 0x0000–0x1FFF.
- R5: While the write-enable latch is 0, neither arr_wr_gnt_o nor sr_wr_gnt_o is asserted for any request.
- R6: With the latch at 1, the pin-guard bit at 1 and wp_ni low, status writes are refused. Array writes to unprotected addresses are still granted.
- R7: With the latch at 1 and either the pin-guard bit at 0 or wp_ni high, a status write is granted.
- R8: A granted array or status write clears the write-enable latch at the next edge. A refused write changes no state.
- R9: status_o carries the pin-guard bit in bit 7, the watchdog select in bits 5:4, the lock code in bits 3:2, the latch in bit 1 and the flag in bit 0. Bit 6 reads 0. Data bits 6, 1 and 0 of a status write are ignored.
- R10: A granted status write loads sr_data_i[7] into the pin-guard bit, sr_data_i[5:4] into the watchdog select and sr_data_i[3:2] into the lock code. Nothing else changes those fields.
- R11: An array write to a protected address is refused whatever the latch, pin and pin-guard state. Protection depends only on the lock code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_set_i | input | 1 | Set write-enable latch strobe |
| we_clr_i | input | 1 | Clear write-enable latch strobe |
| sr_wr_i | input | 1 | Status write request strobe |
| flag_set_i | input | 1 | Set flag strobe |
| flag_clr_i | input | 1 | Clear flag strobe |
| sr_data_i | input | 8 | Data byte of a status write |
| wp_ni | input | 1 | Write-protect pin, active low |
| arr_wr_req_i | input | 1 | Array write request |
| addr_i | input | 13 | Array write target address |
| status_o | output | 8 | Status byte for reads |
| arr_wr_gnt_o | output | 1 | Array write granted this cycle |
| sr_wr_gnt_o | output | 1 | Status write granted this cycle |

## Verification
The grant matrix is swept over every combination of lock code, pin-guard bit, pin level and latch state. In each combination, array requests walk the address space on a fixed stride and also hit each range edge (0x0FFF/0x1000, 0x17FF/0x1800, 0x1FFF). These probes separate a wrong range threshold from a wrong matrix term. Each combination then issues real array and status writes. These show whether a grant clears the latch, whether a refusal leaves every field alone, and whether the shadow fields load from the right data bits. Simultaneous set and clear strobes on the latch and the flag check the priority between them.

// File: rtl/ee_wp_pkg.sv
package ee_wp_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_e;

  // Shadow of the nonvolatile status fields
  typedef struct packed {
    logic       pen;
    logic [1:0] wdsel;
    lock_e      lock;
  } nv_t;

  localparam int NV_W   = $bits(nv_t);
  localparam int STAT_W = 8;

endpackage

// File: rtl/ee_wp_range.sv
module ee_wp_range
  import ee_wp_pkg::*;
(
  input  lock_e      lock_i,
  input  logic [1:0] hi_i,     // two most significant address bits
  output logic       prot_o
);

  // Protection grows from the top of the array downward
  always_comb begin
    unique case (lock_i)
      LOCK_NONE: prot_o = 1'b0;
      LOCK_QTR:  prot_o = (hi_i == 2'b11);
      LOCK_HALF: prot_o = hi_i[1];
      LOCK_ALL:  prot_o = 1'b1;
      default:   prot_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/ee_wp_matrix.sv
module ee_wp_matrix (
  input  logic wel_i,
  input  logic pen_i,
  input  logic wp_ni,
  input  logic prot_i,
  input  logic arr_req_i,
  input  logic sr_req_i,
  output logic arr_gnt_o,
  output logic sr_gnt_o
);

  logic sr_open;

  always_comb begin
    sr_open   = ~pen_i | wp_ni;
    arr_gnt_o = arr_req_i & wel_i & ~prot_i;
    sr_gnt_o  = sr_req_i & wel_i & sr_open;
  end

endmodule

// File: rtl/ee_wp_vol.sv
module ee_wp_vol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wel_set_i,
  input  logic wel_clr_i,
  input  logic flag_set_i,
  input  logic flag_clr_i,
  output logic wel_o,
  output logic flag_o
);

  logic wel_q, wel_d, wel_en;
  logic flag_q, flag_d, flag_en;

  // Next state: clear has priority over set
  always_comb begin
    wel_en  = wel_set_i | wel_clr_i;
    wel_d   = wel_set_i & ~wel_clr_i;
    flag_en = flag_set_i | flag_clr_i;
    flag_d  = flag_set_i & ~flag_clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wel_en)  wel_q  <= wel_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign wel_o  = wel_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/ee_wp_nv.sv
module ee_wp_nv
  import ee_wp_pkg::*;
#(
  parameter nv_t NV_RESET = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  nv_t  data_i,
  output nv_t  nv_o
);

  nv_t nv_q, nv_d;

  always_comb begin
    nv_d = load_i ? data_i : nv_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nv_q <= NV_RESET;
    else if (load_i) nv_q <= nv_d;
  end

  assign nv_o = nv_q;

endmodule

// File: rtl/ee_wp_status.sv
module ee_wp_status
  import ee_wp_pkg::*;
#(
  parameter int  ADDR_W   = 13,
  parameter nv_t NV_RESET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_set_i,
  input  logic              we_clr_i,
  input  logic              sr_wr_i,
  input  logic              flag_set_i,
  input  logic              flag_clr_i,
  input  logic [STAT_W-1:0] sr_data_i,
  input  logic              wp_ni,
  input  logic              arr_wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              arr_wr_gnt_o,
  output logic              sr_wr_gnt_o
);

  localparam int HI_LSB = ADDR_W - 2;

  nv_t  nv, nv_wdata;
  logic wel, flag, prot;
  logic arr_gnt, sr_gnt;
  logic unused_bits;

  assign unused_bits = ^{sr_data_i[6], sr_data_i[1:0], addr_i[HI_LSB-1:0]};

  always_comb begin
    nv_wdata.pen   = sr_data_i[7];
    nv_wdata.wdsel = sr_data_i[5:4];
    nv_wdata.lock  = lock_e'(sr_data_i[3:2]);
  end

  ee_wp_range u_range (
    .lock_i (nv.lock),
    .hi_i   (addr_i[ADDR_W-1:HI_LSB]),
    .prot_o (prot)
  );

  ee_wp_matrix u_matrix (
    .wel_i     (wel),
    .pen_i     (nv.pen),
    .wp_ni     (wp_ni),
    .prot_i    (prot),
    .arr_req_i (arr_wr_req_i),
    .sr_req_i  (sr_wr_i),
    .arr_gnt_o (arr_gnt),
    .sr_gnt_o  (sr_gnt)
  );

  ee_wp_vol u_vol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wel_set_i  (we_set_i),
    .wel_clr_i  (we_clr_i | arr_gnt | sr_gnt),
    .flag_set_i (flag_set_i),
    .flag_clr_i (flag_clr_i),
    .wel_o      (wel),
    .flag_o     (flag)
  );

  ee_wp_nv #(.NV_RESET(NV_RESET)) u_nv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sr_gnt),
    .data_i (nv_wdata),
    .nv_o   (nv)
  );

  always_comb begin
    status_o     = {nv.pen, 1'b0, nv.wdsel, nv.lock, wel, flag};
    arr_wr_gnt_o = arr_gnt;
    sr_wr_gnt_o  = sr_gnt;
  end

endmodule

// File: rtl/ee_wp_status_chk.sv
module ee_wp_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_set_i,
  input logic       we_clr_i,
  input logic       flag_set_i,
  input logic       flag_clr_i,
  input logic [7:0] sr_data_i,
  input logic       wp_ni,
  input logic [7:0] status_o,
  input logic       arr_wr_gnt_o,
  input logic       sr_wr_gnt_o
);

  logic unused_chk;
  assign unused_chk = ^{sr_data_i[6], sr_data_i[1:0], status_o[6]};

  // R5
  wel_low_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] |-> (!arr_wr_gnt_o && !sr_wr_gnt_o));

  // R6
  pin_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !wp_ni) |-> !sr_wr_gnt_o);

  // R11
  all_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:2] == 2'b11) |-> !arr_wr_gnt_o);

  // R8
  gnt_clears_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr_gnt_o || sr_wr_gnt_o) |=> !status_o[1]);

  // R10
  nv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_gnt_o |=> $stable(status_o[7:2]));

  // R10
  nv_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_gnt_o |=> (status_o[7] == $past(sr_data_i[7]) &&
                     status_o[5:2] == $past(sr_data_i[5:2])));

  // R2
  wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_set_i && !we_clr_i && !arr_wr_gnt_o && !sr_wr_gnt_o) |=> status_o[1]);

  // R3
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set_i && !flag_clr_i) |=> status_o[0]);

  // R3
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> !status_o[0]);

endmodule

bind ee_wp_status ee_wp_status_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_set_i     (we_set_i),
  .we_clr_i     (we_clr_i),
  .flag_set_i   (flag_set_i),
  .flag_clr_i   (flag_clr_i),
  .sr_data_i    (sr_data_i),
  .wp_ni        (wp_ni),
  .status_o     (status_o),
  .arr_wr_gnt_o (arr_wr_gnt_o),
  .sr_wr_gnt_o  (sr_wr_gnt_o)
);

// File: tb/ee_wp_status_bench.sv
module ee_wp_status_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        we_set_i, we_clr_i, sr_wr_i, flag_set_i, flag_clr_i;
  logic [7:0]  sr_data_i;
  logic        wp_ni, arr_wr_req_i;
  logic [12:0] addr_i;
  logic [7:0]  status_o;
  logic        arr_wr_gnt_o, sr_wr_gnt_o;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model of the state
  logic       m_wel, m_flag, m_pen;
  logic [1:0] m_wd, m_lock;

  always #4 clk_i = ~clk_i;

  ee_wp_status u_ee_wp_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_set_i     (we_set_i),
    .we_clr_i     (we_clr_i),
    .sr_wr_i      (sr_wr_i),
    .flag_set_i   (flag_set_i),
    .flag_clr_i   (flag_clr_i),
    .sr_data_i    (sr_data_i),
    .wp_ni        (wp_ni),
    .arr_wr_req_i (arr_wr_req_i),
    .addr_i       (addr_i),
    .status_o     (status_o),
    .arr_wr_gnt_o (arr_wr_gnt_o),
    .sr_wr_gnt_o  (sr_wr_gnt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_pen, 1'b0, m_wd, m_lock, m_wel, m_flag};
  endfunction

  function automatic logic is_prot(input logic [1:0] lk, input int a);
    int start;
    if (lk == 2'd0)      start = 8192;
    else if (lk == 2'd3) start = 0;
    else                 start = 8192 - 2048 * int'(lk);
    return a >= start;
  endfunction

  task automatic wel_set();
    @(negedge clk_i); we_set_i = 1'b1;
    @(negedge clk_i); we_set_i = 1'b0;
    m_wel = 1'b1;
  endtask

  task automatic wel_clr();
    @(negedge clk_i); we_clr_i = 1'b1;
    @(negedge clk_i); we_clr_i = 1'b0;
    m_wel = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] d);
    logic g;
    @(negedge clk_i);
    sr_wr_i = 1'b1; sr_data_i = d;
    #1;
    g = m_wel && (!m_pen || wp_ni);
    chk("R5/R6/R7 status write grant", sr_wr_gnt_o, g);
    @(negedge clk_i);
    sr_wr_i = 1'b0;
    if (g) begin
      m_pen = d[7]; m_wd = d[5:4]; m_lock = d[3:2]; m_wel = 1'b0;
    end
    chk("R8/R9/R10 status after status write", status_o, exp_status());
  endtask

  task automatic arr_write(input int a);
    logic g;
    @(negedge clk_i);
    arr_wr_req_i = 1'b1; addr_i = 13'(a);
    #1;
    g = m_wel && !is_prot(m_lock, a);
    chk("R4/R11 array write grant", arr_wr_gnt_o, g);
    @(negedge clk_i);
    arr_wr_req_i = 1'b0;
    if (g) m_wel = 1'b0;
    chk("R8 status after array write", status_o, exp_status());
  endtask

  // grant probe kept clear of the clock edge
  task automatic probe(input int a);
    @(negedge clk_i);
    arr_wr_req_i = 1'b1; addr_i = 13'(a);
    #1;
    chk("R4/R5/R6/R11 array grant sweep", arr_wr_gnt_o, m_wel && !is_prot(m_lock, a));
    #1 arr_wr_req_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    we_set_i = 0; we_clr_i = 0; sr_wr_i = 0; flag_set_i = 0; flag_clr_i = 0;
    sr_data_i = 8'h00; wp_ni = 1'b1; arr_wr_req_i = 1'b0; addr_i = '0;
    m_wel = 0; m_flag = 0; m_pen = 0; m_wd = 0; m_lock = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1
    chk("R1 reset status", status_o, 8'h00);
    arr_wr_req_i = 1'b1; sr_wr_i = 1'b1; #1;
    chk("R1 reset array grant", arr_wr_gnt_o, 1'b0);
    chk("R1 reset status grant", sr_wr_gnt_o, 1'b0);
    arr_wr_req_i = 1'b0; sr_wr_i = 1'b0;

    // R3 flag set, clear, both
    @(negedge clk_i); flag_set_i = 1'b1;
    @(negedge clk_i); flag_set_i = 1'b0;
    chk("R3 flag set", status_o[0], 1'b1);
    @(negedge clk_i); flag_clr_i = 1'b1;
    @(negedge clk_i); flag_clr_i = 1'b0;
    chk("R3 flag clear", status_o[0], 1'b0);
    @(negedge clk_i); flag_set_i = 1'b1;
    @(negedge clk_i); flag_clr_i = 1'b1;
    @(negedge clk_i); flag_set_i = 1'b0; flag_clr_i = 1'b0;
    chk("R3 flag clear wins", status_o[0], 1'b0);

    // R2 latch set, clear, both
    wel_set();
    chk("R2 latch set", status_o, exp_status());
    wel_clr();
    chk("R2 latch clear", status_o, exp_status());
    @(negedge clk_i); we_set_i = 1'b1; we_clr_i = 1'b1;
    @(negedge clk_i); we_set_i = 1'b0; we_clr_i = 1'b0;
    chk("R2 latch clear wins", status_o[1], 1'b0);

    // matrix sweep
    for (int lk = 0; lk < 4; lk++) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int pn = 0; pn < 2; pn++) begin
          for (int wl = 0; wl < 2; wl++) begin
            logic [1:0] l2;
            logic [7:0] d1, d2;
            l2 = 2'(lk);
            d1 = {1'(pe), 1'b0, l2[0], l2[1], l2, 2'b00};
            d2 = {~d1[7], 1'b1, ~d1[5:2], 2'b11};
            wp_ni = 1'b1;
            wel_set();
            sr_write(d1);
            wp_ni = 1'(pn);
            if (wl != 0) wel_set(); else wel_clr();
            chk("R9 status layout", status_o, exp_status());
            for (int a = 0; a < 8192; a += 97) probe(a);
            probe(13'h0FFF); probe(13'h1000);
            probe(13'h17FF); probe(13'h1800); probe(13'h1FFF);
            arr_write(13'h0000);
            if (wl != 0) wel_set();
            arr_write(13'h17FF);
            if (wl != 0) wel_set();
            arr_write(13'h1FFF);
            if (wl != 0) wel_set();
            sr_write(d2);
          end
        end
      end
    end
    wp_ni = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule